// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through data cache and main memory. Every store the processor makes is pushed into a small queue in the same cycle the cache array is updated. A drain engine offers the oldest queued store to the memory side. The memory side takes it by raising a ready signal, so the memory side sets the drain pace. The processor sees a stall only when it issues a store while every slot is occupied and no slot is freed in that cycle.

When the cache misses on a read, the requested address is compared against every occupied slot. If any slot matches, the data of the most recently pushed match is returned, so a read never sees memory contents older than a store still waiting in the queue. An empty flag lets the memory controller hold a read miss back until the queue has drained, in designs that do not use the forwarded data.

Occupancy is tracked by a three-state controller. `SB_EMPTY` means no slot is in use. `SB_PART` means some slots are in use, but not all. `SB_FULL` means every slot is in use. The transitions are:
- FILL_FIRST goes from EMPTY to PART on a push.
- FILL_LAST goes from PART to FULL on a push without a drain, when one slot is free.
- DRAIN_FIRST goes from FULL to PART on a drain without a push.
- DRAIN_LAST goes from PART to EMPTY on a drain without a push, when one slot is in use.
- Every other combination holds the current state, including a push and a drain in the same cycle.

Top module: `wt_store_buffer`

## Requirements
- R1: After reset the buffer reports empty (`sb_empty`=1, `sb_count`=0), `mem_wr_valid`=0 and `st_stall`=0.
- R2: A store presented while fewer than DEPTH (4) slots are used is accepted in that cycle with `st_stall`=0, and `sb_count` rises by one at the next edge if nothing drains.
- R3: A store presented while all 4 slots are used and `mem_wr_ready`=0 raises `st_stall` in that cycle and is not written: count, head entry and lookup results are unchanged afterwards.
- R4: A store presented while full in a cycle where the head entry drains (`mem_wr_ready`=1) is accepted without a stall, and the count stays at 4.
- R5: `mem_wr_valid` is high whenever at least one slot is used; `mem_wr_addr`/`mem_wr_data` show the oldest entry and hold steady while `mem_wr_ready` is low; one entry retires per cycle with ready high.
- R6: The combinational lookup on `lk_addr` raises `lk_hit` when any occupied slot holds that address, and `lk_data` returns the data of the most recently pushed matching entry.
- R7: `lk_hit` is 0 when no occupied slot matches, including addresses whose entries have already drained and stores that were stalled.
- R8: `sb_empty` is 1 exactly when `sb_count` is 0, and `sb_count` never exceeds 4.
- R9: Slot pointers wrap modulo 4, so entries keep arrival order across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor presents a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_stall | output | 1 | Store not taken this cycle; processor must hold it |
| lk_addr | input | ADDR_W | Read-miss address to search |
| lk_hit | output | 1 | A pending store matches `lk_addr` |
| lk_data | output | DATA_W | Data of newest matching pending store |
| mem_wr_valid | output | 1 | Oldest entry offered to memory |
| mem_wr_addr | output | ADDR_W | Address of offered entry |
| mem_wr_data | output | DATA_W | Data of offered entry |
| mem_wr_ready | input | 1 | Memory accepts the offered entry |
| sb_empty | output | 1 | No store pending |
| sb_count | output | CNT_W | Number of occupied slots |

## Verification
The queue is filled with a repeated address, so the forwarding search must choose the newest match over an older one. A separate miss address shows that the search ignores free slots. A fifth store against a full queue with memory held off shows whether the stall blocks the write. The same store repeated with memory ready separates a full-stall design from one that allows a swap. Draining after the write pointer has wrapped, and holding the head under backpressure, separate true arrival order and stable offers from pointer or hold errors.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_EMPTY = 2'd0,
        SB_PART  = 2'd1,
        SB_FULL  = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             mem_ready,
    output logic             push,
    output logic             pop,
    output logic             stall,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    sb_state_e state_q, state_n;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SB_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_n;
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SB_EMPTY: if (push) state_n = SB_PART;                    // FILL_FIRST
            SB_PART: begin
                if (push && !pop && count_q == CNT_W'(DEPTH - 1))
                    state_n = SB_FULL;                                // FILL_LAST
                else if (pop && !push && count_q == CNT_W'(1))
                    state_n = SB_EMPTY;                               // DRAIN_LAST
            end
            SB_FULL: if (pop && !push) state_n = SB_PART;             // DRAIN_FIRST
            default: state_n = SB_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        empty = (state_q == SB_EMPTY);
        full  = (state_q == SB_FULL);
        pop   = !empty && mem_ready;
        push  = st_valid && (!full || pop);
        stall = st_valid && full && !pop;
        count = count_q;
    end

    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SB_EMPTY) == (count_q == '0));
    a_r3_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (count_q == CNT_W'(DEPTH)) && !mem_ready);
    a_r2_free_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && count_q < CNT_W'(DEPTH)) |-> !stall);
    a_r4_swap_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && full && mem_ready) |=> (count_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/sb_storage.sv
module sb_storage #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [DATA_W-1:0]             in_data,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [DATA_W-1:0]             head_data,
    output logic [PTR_W-1:0]              rd_ptr,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);
    logic [PTR_W-1:0] wr_q, rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;   // wraps modulo DEPTH
            if (pop)  rd_q <= rd_q + 1'b1;
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[s] <= '0;
                slot_data[s] <= '0;
            end else if (push && wr_q == PTR_W'(s)) begin
                slot_addr[s] <= in_addr;
                slot_data[s] <= in_data;
            end
        end
    end

    assign rd_ptr    = rd_q;
    assign head_addr = slot_addr[rd_q];
    assign head_data = slot_data[rd_q];
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             q_addr,
    input  logic [PTR_W-1:0]              rd_ptr,
    input  logic [CNT_W-1:0]              count,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    output logic                          hit,
    output logic [DATA_W-1:0]             data
);
    // walk oldest to newest; a later match overrides an earlier one
    always_comb begin
        logic [PTR_W-1:0] idx;
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = rd_ptr + PTR_W'(k);
            if (CNT_W'(k) < count && slot_addr[idx] == q_addr) begin
                hit  = 1'b1;
                data = slot_data[idx];
            end
        end
    end

    a_r7_no_hit_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !hit);
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_stall,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              sb_empty,
    output logic [CNT_W-1:0]  sb_count
);
    logic push, pop, full;
    logic [PTR_W-1:0] rd_ptr;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;

    sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .mem_ready(mem_wr_ready),
        .push(push), .pop(pop), .stall(st_stall), .empty(sb_empty),
        .full(full), .count(sb_count)
    );

    sb_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .in_addr(st_addr), .in_data(st_data),
        .head_addr(mem_wr_addr), .head_data(mem_wr_data), .rd_ptr(rd_ptr),
        .slot_addr(slot_addr), .slot_data(slot_data)
    );

    sb_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_lookup (
        .clk(clk), .rst_n(rst_n), .q_addr(lk_addr), .rd_ptr(rd_ptr),
        .count(sb_count), .slot_addr(slot_addr), .slot_data(slot_data),
        .hit(lk_hit), .data(lk_data)
    );

    assign mem_wr_valid = !sb_empty;

    a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    a_r3_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stall && full) |=> $stable(sb_count));
endmodule

// File: tb/wt_store_buffer_test.sv
module wt_store_buffer_test;
    localparam int AW = 32, DW = 32, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 1'b0, mem_wr_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, lk_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_stall, lk_hit, mem_wr_valid, sb_empty;
    logic [DW-1:0] lk_data, mem_wr_data;
    logic [AW-1:0] mem_wr_addr;
    logic [CW-1:0] sb_count;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    wt_store_buffer uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_stall(st_stall), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_data(lk_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready), .sb_empty(sb_empty), .sb_count(sb_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // store presented one cycle; stall checked before the edge
    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic rdy, input logic exp_stall, input string req);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; mem_wr_ready = rdy;
        #1 chk(req, st_stall, exp_stall);
        @(posedge clk); #1;
        st_valid = 1'b0; mem_wr_ready = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic exp_hit,
                          input logic [DW-1:0] exp_d, input string req);
        @(negedge clk);
        lk_addr = a;
        #1 chk(req, lk_hit, exp_hit);
        if (exp_hit) chk(req, lk_data, exp_d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 empty", sb_empty, 1'b1);
        chk("R1 count", sb_count, 0);
        chk("R1 valid", mem_wr_valid, 1'b0);
        chk("R1 stall", st_stall, 1'b0);
    endtask

    task automatic t_fill();
        store(32'h100, 32'hD1, 1'b0, 1'b0, "R2 store0");
        store(32'h200, 32'hD2, 1'b0, 1'b0, "R2 store1");
        store(32'h100, 32'hD3, 1'b0, 1'b0, "R2 store2");
        store(32'h300, 32'hD4, 1'b0, 1'b0, "R2 store3");
        @(negedge clk);
        chk("R2 count4", sb_count, 4);
        chk("R8 not empty", sb_empty, 1'b0);
        chk("R5 valid", mem_wr_valid, 1'b1);
        chk("R5 head oldest", mem_wr_addr, 32'h100);
    endtask

    task automatic t_full_stall();
        store(32'h999, 32'hEE, 1'b0, 1'b1, "R3 stall");
        @(negedge clk);
        chk("R3 count kept", sb_count, 4);
        chk("R3 head kept", mem_wr_addr, 32'h100);
        lookup(32'h999, 1'b0, '0, "R7 stalled store absent");
    endtask

    task automatic t_forward();
        lookup(32'h100, 1'b1, 32'hD3, "R6 newest of two");
        lookup(32'h200, 1'b1, 32'hD2, "R6 single");
        lookup(32'h400, 1'b0, '0, "R7 miss");
    endtask

    task automatic t_swap();
        store(32'h500, 32'hD5, 1'b1, 1'b0, "R4 no stall on swap");
        @(negedge clk);
        chk("R4 count stays 4", sb_count, 4);
        chk("R4 head advanced", mem_wr_addr, 32'h200);
        lookup(32'h100, 1'b1, 32'hD3, "R6 after swap");
    endtask

    task automatic t_drain_wrap();
        logic [AW-1:0] ea [4] = '{32'h200, 32'h100, 32'h300, 32'h500};
        logic [DW-1:0] ed [4] = '{32'hD2, 32'hD3, 32'hD4, 32'hD5};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            mem_wr_ready = 1'b1;
            #1;
            chk("R5 valid while draining", mem_wr_valid, 1'b1);
            chk("R9 order addr", mem_wr_addr, ea[i]);
            chk("R9 order data", mem_wr_data, ed[i]);
            @(posedge clk); #1;
        end
        mem_wr_ready = 1'b0;
        @(negedge clk);
        chk("R8 empty after drain", sb_empty, 1'b1);
        chk("R8 count zero", sb_count, 0);
        chk("R5 no offer when empty", mem_wr_valid, 1'b0);
        lookup(32'h100, 1'b0, '0, "R7 drained entry stale");
    endtask

    task automatic t_backpressure();
        store(32'h600, 32'hD6, 1'b0, 1'b0, "R2 store into empty");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 hold addr", mem_wr_addr, 32'h600);
            chk("R5 hold data", mem_wr_data, 32'hD6);
        end
        store(32'h700, 32'hD7, 1'b1, 1'b0, "R2 push with pop");
        @(negedge clk);
        chk("R8 count one", sb_count, 1);
        chk("R5 next head", mem_wr_addr, 32'h700);
        @(negedge clk); mem_wr_ready = 1'b1;
        @(posedge clk); #1 mem_wr_ready = 1'b0;
        @(negedge clk);
        chk("R8 empty again", sb_empty, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_full_stall();
        t_forward();
        t_swap();
        t_drain_wrap();
        t_backpressure();
        finish_run();
    end
endmodule